// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two data buses, side A and side B, and can pass a word across in either direction. Each bus is modelled as three signals: an input bus, an output bus and an output enable. No tri-state pins are used. Each side has its own storage register. For each direction, a select input chooses what goes onto the far bus. A low select sends the live word from the near bus. A high select sends the word held in that direction's register.

A load strobe for each register, sampled on the system clock, captures the word present on that register's bus. When the block is driving that bus, the captured word is the one the block drives. The loads work whatever the selects and enables are set to. This lets one clock edge copy a word into both registers.

The parameter `EN_STYLE` picks the enable style. The single style uses one active-low enable and a direction input. The dual style uses an active-high B enable and an active-low A enable, and can drive both buses at once. The parameter `INVERT` makes the block drive the complement of the selected word.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-low reset clears both storage registers to zero, and it overrides any load strobe asserted in the same cycle.
- R2: When `a_store_ld` is high at a clock edge, the A register takes the word on the A bus. The A bus word is `a_in` when `a_oe` is low and `a_out` when `a_oe` is high. `b_store_ld` does the same for the B register and the B bus. Selects and enables have no effect on capture.
- R3: While `b_src_stored` is 0, `b_out` equals the A bus word in the same cycle, with no register in the path. While it is 1, `b_out` equals the A register.
- R4: While `a_src_stored` is 0, `a_out` equals the B bus word in the same cycle. While it is 1, `a_out` equals the B register.
- R5: Single style (`EN_STYLE`=0): `xen_n`=1 clears both enables. With `xen_n`=0, `to_b_dir`=0 sets only `a_oe` and `to_b_dir`=1 sets only `b_oe`. `b_drive_en` and `a_drive_en_n` have no effect.
- R6: Dual style (`EN_STYLE`=1): `b_oe` follows `b_drive_en` (active high) and `a_oe` follows `a_drive_en_n` (active low). `xen_n` and `to_b_dir` have no effect.
- R7: With both enables on and both selects at 1, `a_out` shows the B register and `b_out` shows the A register in the same cycle.
- R8: If the block drives only B from live A while both strobes are high, one edge loads the A word into both registers. If it drives only A from live B, one edge loads the B word into both.
- R9: If both enables are on and both selects are 0, `loop_err` is 1, `a_out` shows the B register and `b_out` shows the A register. In every other case `loop_err` is 0.
- R10: With `INVERT`=1, each output carries the bitwise complement of the word chosen by R3, R4, R7 and R9.
- R11: A register with its load strobe low keeps its value from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; register loads occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | DATA_W | Word arriving from the A bus |
| a_out | output | DATA_W | Word to drive onto the A bus |
| a_oe | output | 1 | A bus output enable |
| b_in | input | DATA_W | Word arriving from the B bus |
| b_out | output | DATA_W | Word to drive onto the B bus |
| b_oe | output | 1 | B bus output enable |
| a_store_ld | input | 1 | Load strobe for the A-side register |
| b_store_ld | input | 1 | Load strobe for the B-side register |
| b_src_stored | input | 1 | B output source: 0 live A, 1 stored A |
| a_src_stored | input | 1 | A output source: 0 live B, 1 stored B |
| xen_n | input | 1 | Single style: active-low enable |
| to_b_dir | input | 1 | Single style: 1 drives B, 0 drives A |
| b_drive_en | input | 1 | Dual style: active-high B output enable |
| a_drive_en_n | input | 1 | Dual style: active-low A output enable |
| loop_err | output | 1 | Both buses enabled with both selects live |

## Verification
Enables, `loop_err` and both outputs are combinational. They are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. A load or a reset shows up only after the next rising edge. So each register value is read in the vector after the one that strobed it, by setting the select to stored. The bench also reads every register in a vector without a strobe. This shows that the register keeps its value.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered bus transceiver.
// Assumes: nothing; holds only type definitions.
package xcvr_pkg;

    // Enable style choice for the transceiver
    typedef enum logic {
        EN_SINGLE_DIR = 1'b0,  // one active-low enable plus a direction input
        EN_DUAL       = 1'b1   // independent enables per bus
    } en_style_e;

endpackage

// File: rtl/xcvr_enable_decode.sv
// Module: turns the enable inputs into per-bus output enables and
// flags the combinational loop case (both buses driven, both live).
// Assumes: only the inputs of the chosen style matter; the others are ignored.
module xcvr_enable_decode
    import xcvr_pkg::*;
#(
    parameter en_style_e EN_STYLE = EN_DUAL
) (
    input  logic xen_n,
    input  logic to_b_dir,
    input  logic b_drive_en,
    input  logic a_drive_en_n,
    input  logic a_src_stored,
    input  logic b_src_stored,
    output logic a_oe,
    output logic b_oe,
    output logic loop_err
);

    localparam logic DUAL = (EN_STYLE == EN_DUAL);

    // Pick the per-bus enables according to the style parameter
    always_comb begin
        a_oe = DUAL ? !a_drive_en_n : (!xen_n && !to_b_dir);
        b_oe = DUAL ? b_drive_en    : (!xen_n &&  to_b_dir);
    end

    // A loop exists only when each bus feeds the other live
    always_comb begin
        loop_err = a_oe && b_oe && !a_src_stored && !b_src_stored;
    end

endmodule

// File: rtl/xcvr_store_reg.sv
// Module: one storage register with a load strobe.
// Assumes: synchronous active-low reset clears to zero and wins over load.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the bus word on a strobed edge, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));

endmodule

// File: rtl/xcvr_route.sv
// Module: chooses the word for each output and works out the word seen on
// each bus, which is what the registers capture.
// Assumes: the loop case is resolved by the enable decoder; with optional
// inversion, a driven bus carries the already inverted word.
module xcvr_route #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    input  logic         a_oe,
    input  logic         b_oe,
    input  logic         a_src_stored,
    input  logic         b_src_stored,
    input  logic         loop_err,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus
);

    localparam logic [W-1:0] MASK = {W{INVERT}};

    logic [W-1:0] st_to_a;
    logic [W-1:0] st_to_b;

    // Stored words as they would leave the block
    always_comb begin
        st_to_a = reg_b ^ MASK;
        st_to_b = reg_a ^ MASK;
    end

    // Resolve the outputs in dependency order so that no path loops back
    always_comb begin
        a_out = st_to_a;
        b_out = st_to_b;
        a_bus = a_in;
        b_bus = b_in;
        if (loop_err) begin
            a_out = st_to_a;
            b_out = st_to_b;
            a_bus = a_out;
            b_bus = b_out;
        end else if (b_src_stored) begin
            b_out = st_to_b;
            b_bus = b_oe ? b_out : b_in;
            a_out = a_src_stored ? st_to_a : (b_bus ^ MASK);
            a_bus = a_oe ? a_out : a_in;
        end else if (a_oe) begin
            a_out = a_src_stored ? st_to_a : (b_in ^ MASK);
            a_bus = a_out;
            b_out = a_bus ^ MASK;
            b_bus = b_oe ? b_out : b_in;
        end else begin
            a_bus = a_in;
            b_out = a_in ^ MASK;
            b_bus = b_oe ? b_out : b_in;
            a_out = a_src_stored ? st_to_a : (b_bus ^ MASK);
        end
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
// Module: top of the registered bidirectional bus transceiver.
// Each bus is a separate input, output and enable. Each direction sends
// either live data or its own stored word. Each register takes the word
// seen on its bus when its load strobe is high at a clock edge.
// Assumes: load strobes are synchronous to clk; reset is synchronous, active low.
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int        DATA_W   = 8,
    parameter en_style_e EN_STYLE = EN_DUAL,
    parameter bit        INVERT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe,
    input  logic              a_store_ld,
    input  logic              b_store_ld,
    input  logic              b_src_stored,
    input  logic              a_src_stored,
    input  logic              xen_n,
    input  logic              to_b_dir,
    input  logic              b_drive_en,
    input  logic              a_drive_en_n,
    output logic              loop_err
);

    localparam int           NSIDE = 2;
    localparam logic [DATA_W-1:0] MASK = {DATA_W{INVERT}};

    logic [DATA_W-1:0] bus_w [NSIDE];
    logic [DATA_W-1:0] reg_w [NSIDE];
    logic              ld_w  [NSIDE];
    logic [DATA_W-1:0] a_bus;
    logic [DATA_W-1:0] b_bus;

    xcvr_enable_decode #(
        .EN_STYLE(EN_STYLE)
    ) u_dec (
        .xen_n        (xen_n),
        .to_b_dir     (to_b_dir),
        .b_drive_en   (b_drive_en),
        .a_drive_en_n (a_drive_en_n),
        .a_src_stored (a_src_stored),
        .b_src_stored (b_src_stored),
        .a_oe         (a_oe),
        .b_oe         (b_oe),
        .loop_err     (loop_err)
    );

    xcvr_route #(
        .W      (DATA_W),
        .INVERT (INVERT)
    ) u_route (
        .a_in         (a_in),
        .b_in         (b_in),
        .reg_a        (reg_w[0]),
        .reg_b        (reg_w[1]),
        .a_oe         (a_oe),
        .b_oe         (b_oe),
        .a_src_stored (a_src_stored),
        .b_src_stored (b_src_stored),
        .loop_err     (loop_err),
        .a_out        (a_out),
        .b_out        (b_out),
        .a_bus        (a_bus),
        .b_bus        (b_bus)
    );

    // Map each side's bus word and strobe onto the register array
    always_comb begin
        bus_w[0] = a_bus;
        bus_w[1] = b_bus;
        ld_w[0]  = a_store_ld;
        ld_w[1]  = b_store_ld;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_store
        xcvr_store_reg #(
            .W(DATA_W)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld_w[s]),
            .d     (bus_w[s]),
            .q     (reg_w[s])
        );
    end

    assert_stored_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        b_src_stored |-> (b_out == (reg_w[0] ^ MASK)));

    assert_live_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_src_stored && !loop_err && !a_oe) |-> (b_out == (a_in ^ MASK)));

    assert_stored_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
        a_src_stored |-> (a_out == (reg_w[1] ^ MASK)));

    assert_loop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_err |-> ((a_out == (reg_w[1] ^ MASK)) && (b_out == (reg_w[0] ^ MASK))));

    if (EN_STYLE == EN_SINGLE_DIR) begin : g_single_chk
        assert_one_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe && b_oe));
    end

endmodule

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb;
    import xcvr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic a_store_ld = 0, b_store_ld = 0, b_src_stored = 0, a_src_stored = 0;
    logic xen_n = 0, to_b_dir = 0, b_drive_en = 0, a_drive_en_n = 1;

    logic [7:0] a_out, b_out, s_a_out, s_b_out, i_a_out, i_b_out;
    logic a_oe, b_oe, loop_err, s_a_oe, s_b_oe, s_loop, i_a_oe, i_b_oe, i_loop;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_xcvr_reg #(.DATA_W(8), .EN_STYLE(EN_DUAL), .INVERT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .a_store_ld(a_store_ld),
        .b_store_ld(b_store_ld), .b_src_stored(b_src_stored),
        .a_src_stored(a_src_stored), .xen_n(xen_n), .to_b_dir(to_b_dir),
        .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n), .loop_err(loop_err));

    bus_xcvr_reg #(.DATA_W(8), .EN_STYLE(EN_SINGLE_DIR), .INVERT(1'b0)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(s_a_out), .a_oe(s_a_oe),
        .b_in(b_in), .b_out(s_b_out), .b_oe(s_b_oe), .a_store_ld(a_store_ld),
        .b_store_ld(b_store_ld), .b_src_stored(b_src_stored),
        .a_src_stored(a_src_stored), .xen_n(xen_n), .to_b_dir(to_b_dir),
        .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n), .loop_err(s_loop));

    bus_xcvr_reg #(.DATA_W(8), .EN_STYLE(EN_DUAL), .INVERT(1'b1)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(i_a_out), .a_oe(i_a_oe),
        .b_in(b_in), .b_out(i_b_out), .b_oe(i_b_oe), .a_store_ld(a_store_ld),
        .b_store_ld(b_store_ld), .b_src_stored(b_src_stored),
        .a_src_stored(a_src_stored), .xen_n(xen_n), .to_b_dir(to_b_dir),
        .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n), .loop_err(i_loop));

    // Vector: {b_drive_en, a_drive_en_n, b_src_stored, a_src_stored, a_ld, b_ld,
    //          a_in, b_in, {a_oe, b_oe, loop_err}, exp a_out, exp b_out}
    localparam int NV = 13;
    localparam logic [40:0] VEC [0:NV-1] = '{
        {6'b010011, 8'h3C, 8'hA5, 3'b000, 8'h00, 8'h00},
        {6'b101100, 8'h00, 8'h00, 3'b110, 8'hA5, 8'h3C},
        {6'b110000, 8'h5A, 8'hFF, 3'b010, 8'h00, 8'h5A},
        {6'b000000, 8'h11, 8'hC3, 3'b100, 8'hC3, 8'h00},
        {6'b000100, 8'h11, 8'hC3, 3'b100, 8'hA5, 8'h00},
        {6'b110011, 8'hE7, 8'h00, 3'b010, 8'h00, 8'hE7},
        {6'b101100, 8'h00, 8'h00, 3'b110, 8'hE7, 8'hE7},
        {6'b100000, 8'h12, 8'h34, 3'b111, 8'hE7, 8'hE7},
        {6'b000011, 8'h00, 8'h81, 3'b100, 8'h81, 8'h00},
        {6'b101100, 8'hFF, 8'hFF, 3'b110, 8'h81, 8'h81},
        {6'b100100, 8'h00, 8'h00, 3'b110, 8'h81, 8'h81},
        {6'b111010, 8'h66, 8'h00, 3'b010, 8'h00, 8'h81},
        {6'b111000, 8'h00, 8'h00, 3'b010, 8'h00, 8'h66}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R2";
            1: return "R2 R7";
            2: return "R3";
            3: return "R4";
            4: return "R4";
            5: return "R3 R8";
            6: return "R8 R7";
            7: return "R9";
            8: return "R4 R8";
            9: return "R11";
            10: return "R9";
            11: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_store_ld = 0; b_store_ld = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: registers start cleared
        @(negedge clk);
        b_drive_en = 1; a_drive_en_n = 0; b_src_stored = 1; a_src_stored = 1;
        #1;
        chk("R1 a_out after reset", a_out, 8'h00);
        chk("R1 b_out after reset", b_out, 8'h00);
        chk("R7 loop_err low", {7'd0, loop_err}, 8'h00);

        // R10: inverted variant, registers zero
        @(negedge clk);
        b_drive_en = 1; a_drive_en_n = 1; b_src_stored = 1; a_src_stored = 0;
        #1;
        chk("R10 stored inverted", i_b_out, 8'hFF);
        @(negedge clk);
        b_src_stored = 0; a_in = 8'h0F;
        #1;
        chk("R10 live inverted to B", i_b_out, 8'hF0);
        @(negedge clk);
        b_drive_en = 0; a_drive_en_n = 0; b_in = 8'h3C;
        #1;
        chk("R10 live inverted to A", i_a_out, 8'hC3);

        // Table walk on the dual-enable instance; R6: xen_n/to_b_dir ignored
        xen_n = 0; to_b_dir = 1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {b_drive_en, a_drive_en_n, b_src_stored, a_src_stored, a_store_ld, b_store_ld}
                = VEC[i][40:35];
            a_in = VEC[i][34:27];
            b_in = VEC[i][26:19];
            #1;
            chk({vtag(i), " R6 a_oe"}, {7'd0, a_oe}, {7'd0, VEC[i][18]});
            chk({vtag(i), " R6 b_oe"}, {7'd0, b_oe}, {7'd0, VEC[i][17]});
            chk({vtag(i), " R9 loop_err"}, {7'd0, loop_err}, {7'd0, VEC[i][16]});
            if (VEC[i][18]) chk({vtag(i), " a_out"}, a_out, VEC[i][15:8]);
            if (VEC[i][17]) chk({vtag(i), " b_out"}, b_out, VEC[i][7:0]);
        end

        // R5 single style: dual enables ignored, xen_n high isolates
        @(negedge clk);
        idle();
        xen_n = 1; to_b_dir = 1; b_drive_en = 1; a_drive_en_n = 0;
        b_src_stored = 0; a_src_stored = 0;
        #1;
        chk("R5 isolated a_oe", {7'd0, s_a_oe}, 8'h00);
        chk("R5 isolated b_oe", {7'd0, s_b_oe}, 8'h00);
        chk("R6 dual ignores xen_n", {6'd0, a_oe, b_oe}, 8'h03);
        @(negedge clk);
        xen_n = 0; to_b_dir = 0; b_drive_en = 0; a_drive_en_n = 1;
        #1;
        chk("R5 dir0 enables", {6'd0, s_a_oe, s_b_oe}, 8'h02);
        @(negedge clk);
        to_b_dir = 1; a_in = 8'h9C;
        #1;
        chk("R5 dir1 enables", {6'd0, s_a_oe, s_b_oe}, 8'h01);
        chk("R3 single live to B", s_b_out, 8'h9C);
        chk("R9 single never loops", {7'd0, s_loop}, 8'h00);

        // R1: reset wins over load strobes
        @(negedge clk);
        rst_n = 0; a_store_ld = 1; b_store_ld = 1; a_in = 8'hFF; b_in = 8'hFF;
        b_drive_en = 0; a_drive_en_n = 1;
        @(negedge clk);
        rst_n = 1; idle();
        b_drive_en = 1; a_drive_en_n = 0; b_src_stored = 1; a_src_stored = 1;
        #1;
        chk("R1 reset over load A", b_out, 8'h00);
        chk("R1 reset over load B", a_out, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-stall actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule